// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A host writes bytes into a transmit FIFO through a one-cycle write strobe. A shifter takes them out one at a time and sends each as a frame: a low start bit, then the data bits least significant first, then an optional parity bit, then one or two high stop bits. A separate baud generator supplies a one-cycle tick, and each bit on the line lasts exactly one tick interval. The frame shape comes from static control inputs: enable, data length, parity enable, parity sense and stop-bit count.

The host sees FIFO full, FIFO empty and shifter busy as separate flags. A byte has fully left the block only when the FIFO is empty and the shifter is idle. A write to a full FIFO is dropped and sets a sticky error flag. That flag stays set until the host holds the clear-error level high. A level interrupt requests more data while the FIFO occupancy is at or below an 8-bit threshold. Integrators normally tie the threshold to half the FIFO depth, which is 32 for the default depth of 64.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line is high, the FIFO-empty flag is 1, and the full, busy and write-error flags are 0. The line is high whenever busy is 0.
- R2: A frame is one low start bit followed by the data bits, least significant bit first. The 2-bit length code gives the number of data bits: 00 gives 8, 01 gives 7, 10 gives 6 and 11 gives 5. Upper byte bits beyond the length are not sent.
- R3: When parity enable is 1, one parity bit follows the data bits. With parity type 1 the data bits plus the parity bit hold an odd number of ones. With parity type 0 they hold an even number.
- R4: Stop bits are high. Stop code 01 gives two stop bits. Code 00 gives one, and the unused codes 10 and 11 also give one.
- R5: Busy is 1 from the start bit to the end of the last stop bit, including the time when the FIFO is already empty. Transmission is complete only when FIFO empty is 1 and busy is 0.
- R6: Every bit lasts exactly one baud-tick interval. The line changes only on a clock edge that carries a tick. A frame starts on a tick when transmit is enabled and the FIFO holds a byte. Queued bytes go out back to back, with no idle bit between frames.
- R7: The FIFO holds DEPTH bytes (64 by default), and full is 1 at that occupancy. A write while full is dropped and is never transmitted.
- R8: A write while full sets a sticky write-error flag. The flag is 0 on every cycle after a cycle in which the clear-error input is high, even if further writes to a full FIFO arrive. Once the input returns low, the flag can be set again.
- R9: The interrupt output is 1 exactly when interrupt enable is 1 and the FIFO count is less than or equal to the 8-bit threshold.
- R10: A transmit-reset pulse empties the FIFO by the next cycle, and the flushed bytes are never transmitted.
- R11: When transmit enable goes low, the frame in progress completes and no further byte is taken from the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_rst | input | 1 | Synchronous FIFO flush |
| tx_en | input | 1 | Allows new frames to start |
| len_code | input | 2 | Data length code (00=8, 01=7, 10=6, 11=5) |
| par_en | input | 1 | Adds a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| stop_code | input | 2 | 01 selects two stop bits, otherwise one |
| baud_tick | input | 1 | One-cycle bit-timing pulse |
| wr_en | input | 1 | Write strobe into the FIFO |
| wr_data | input | 8 | Byte to queue |
| clr_err | input | 1 | Level that clears the write-error flag |
| irq_en | input | 1 | Interrupt enable |
| irq_thresh | input | 8 | Occupancy threshold for the interrupt |
| txd | output | 1 | Serial line |
| fifo_full | output | 1 | FIFO holds DEPTH bytes |
| fifo_empty | output | 1 | FIFO holds no bytes |
| busy | output | 1 | A frame is on the line |
| wr_err | output | 1 | Sticky write-while-full error |
| irq | output | 1 | Transmit interrupt level |

## Verification
The bench decodes the line one tick at a time. A design that put the parity bit on the wrong side of even/odd, took the length code the wrong way round, or added a gap between back-to-back frames would show up as a frame mismatch. The bench watches the moment the FIFO drains while the last frame is still on the line: a design that dropped busy together with empty would lose that check. It fills the FIFO and writes once more: a design that accepted that byte would emit an extra frame. It holds clear-error while still writing to the full FIFO: a design that treated clear-error as a one-shot pulse would let the flag come back early. It also checks the interrupt at a count equal to the threshold and one above it, and it drops enable in the middle of a frame to catch a design that abandons the frame or keeps draining the FIFO.

// File: rtl/uft_pkg.sv
package uft_pkg;
  localparam int FRAME_MAX = 12;

  typedef struct packed {
    logic [FRAME_MAX-1:0] bits;
    logic [3:0]           nbits;
  } frame_t;

  // data bit count from the length code: 00->8 ... 11->5
  function automatic logic [3:0] data_count(input logic [1:0] code);
    return 4'd8 - {2'b00, code};
  endfunction

  function automatic logic parity_bit(input logic [7:0] d, input logic [1:0] code,
                                      input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < 8; i++)
      if (4'(i) < data_count(code)) p = p ^ d[i];
    return p;
  endfunction

  // line bits in send order, LSB first, padded with idle ones
  function automatic frame_t build_frame(input logic [7:0] d, input logic [1:0] code,
                                         input logic pen, input logic podd,
                                         input logic [1:0] stop);
    frame_t f;
    logic [3:0] pos;
    f.bits = '1;
    f.bits[0] = 1'b0;
    pos = 4'd1;
    for (int i = 0; i < 8; i++) begin
      if (4'(i) < data_count(code)) begin
        f.bits[pos] = d[i];
        pos = pos + 4'd1;
      end
    end
    if (pen) begin
      f.bits[pos] = parity_bit(d, code, podd);
      pos = pos + 4'd1;
    end
    pos = pos + ((stop == 2'b01) ? 4'd2 : 4'd1);
    f.nbits = pos;
    return f;
  endfunction
endpackage

// File: rtl/uft_fifo.sv
module uft_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count,
  input  logic          clr_err,
  output logic          wr_err
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          err_q;

  logic push_ok, pop_ok;
  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              err_q <= 1'b0;
    else if (clr_err)        err_q <= 1'b0;
    else if (push && full)   err_q <= 1'b1;
  end

  assign dout   = mem[rd_ptr];
  assign count  = cnt_q;
  assign wr_err = err_q;

  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> full)
    else $error("write to full FIFO changed occupancy");
  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> !wr_err)
    else $error("write error survived clear level");
  // R10
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty)
    else $error("flush left data in FIFO");
endmodule

// File: rtl/uft_shifter.sv
module uft_shifter
  import uft_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       tx_en,
  input  logic       have_data,
  input  logic [7:0] din,
  input  logic [1:0] len_code,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [1:0] stop_code,
  output logic       pop,
  output logic       busy,
  output logic       txd
);
  logic [FRAME_MAX-1:0] frame_q;
  logic [3:0]           nbits_q, cnt_q;
  logic                 busy_q;
  frame_t               next_f;
  logic                 last_bit, load;

  assign next_f   = build_frame(din, len_code, par_en, par_odd, stop_code);
  assign last_bit = busy_q && (cnt_q == nbits_q - 4'd1);
  assign load     = tick && tx_en && have_data && (!busy_q || last_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      nbits_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else if (load) begin
      frame_q <= next_f.bits;
      nbits_q <= next_f.nbits;
      cnt_q   <= '0;
      busy_q  <= 1'b1;
    end else if (tick && busy_q) begin
      if (last_bit) begin
        busy_q <= 1'b0;
      end else begin
        frame_q <= {1'b1, frame_q[FRAME_MAX-1:1]};
        cnt_q   <= cnt_q + 4'd1;
      end
    end
  end

  assign pop  = load;
  assign busy = busy_q;
  assign txd  = busy_q ? frame_q[0] : 1'b1;

  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd)
    else $error("line low while idle");
  // R6
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(txd))
    else $error("line moved without a tick");
  // R11
  no_start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tx_en) |=> !busy)
    else $error("frame started while disabled");
endmodule

// File: rtl/uft_irq_cmp.sv
module uft_irq_cmp #(
  parameter int CW    = 7,
  parameter int TW    = 8,
  localparam int MW   = (CW > TW) ? CW : TW
) (
  input  logic          irq_en,
  input  logic [CW-1:0] count,
  input  logic [TW-1:0] thresh,
  output logic          irq
);
  logic [MW-1:0] c_ext, t_ext;
  assign c_ext = MW'(count);
  assign t_ext = MW'(thresh);
  assign irq   = irq_en && (c_ext <= t_ext);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_rst,
  input  logic       tx_en,
  input  logic [1:0] len_code,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [1:0] stop_code,
  input  logic       baud_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       clr_err,
  input  logic       irq_en,
  input  logic [7:0] irq_thresh,
  output logic       txd,
  output logic       fifo_full,
  output logic       fifo_empty,
  output logic       busy,
  output logic       wr_err,
  output logic       irq
);
  logic          pop;
  logic [7:0]    head;
  logic [CW-1:0] count;

  uft_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(tx_rst), .push(wr_en), .din(wr_data),
    .pop(pop), .dout(head), .full(fifo_full), .empty(fifo_empty),
    .count(count), .clr_err(clr_err), .wr_err(wr_err)
  );

  uft_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .tx_en(tx_en),
    .have_data(!fifo_empty && !tx_rst), .din(head), .len_code(len_code),
    .par_en(par_en), .par_odd(par_odd), .stop_code(stop_code),
    .pop(pop), .busy(busy), .txd(txd)
  );

  uft_irq_cmp #(.CW(CW), .TW(8)) u_irq (
    .irq_en(irq_en), .count(count), .thresh(irq_thresh), .irq(irq)
  );

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en)
    else $error("interrupt without enable");
  // R9
  irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && fifo_empty) |-> irq)
    else $error("interrupt missing at zero occupancy");
endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  localparam int DEPTH = 64;
  localparam int DIV   = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, tx_rst = 1'b0, tx_en = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic [1:0] len_code = 2'b00, stop_code = 2'b00;
  logic baud_tick = 1'b0, wr_en = 1'b0, clr_err = 1'b0, irq_en = 1'b0;
  logic [7:0] wr_data = '0, irq_thresh = 8'd32;
  logic txd, fifo_full, fifo_empty, busy, wr_err, irq;

  uart_frame_tx #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .tx_rst(tx_rst), .tx_en(tx_en), .len_code(len_code),
    .par_en(par_en), .par_odd(par_odd), .stop_code(stop_code), .baud_tick(baud_tick),
    .wr_en(wr_en), .wr_data(wr_data), .clr_err(clr_err), .irq_en(irq_en),
    .irq_thresh(irq_thresh), .txd(txd), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .busy(busy), .wr_err(wr_err), .irq(irq)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] d; logic [1:0] len; logic pen; logic podd; logic [1:0] stop;
  } item_t;
  item_t sb[$];

  int tcnt = 0;
  always @(negedge clk) begin
    if (tcnt == DIV - 1) begin tcnt <= 0; baud_tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; baud_tick <= 1'b0; end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected line bits, built from the requirements
  function automatic void exp_frame(input item_t it, output logic [11:0] bits, output int n);
    int nd;
    logic [7:0] mask;
    case (it.len)
      2'b00: nd = 8;
      2'b01: nd = 7;
      2'b10: nd = 6;
      default: nd = 5;
    endcase
    mask = 8'hFF >> (8 - nd);
    bits = '1;
    bits[0] = 1'b0;
    n = 1;
    for (int i = 0; i < nd; i++) begin bits[n] = it.d[i]; n++; end
    if (it.pen) begin bits[n] = (^(it.d & mask)) ^ it.podd; n++; end
    n += (it.stop == 2'b01) ? 2 : 1;
  endfunction

  task automatic get_bit(output logic b);
    @(posedge clk);
    while (!baud_tick) @(posedge clk);
    @(negedge clk);
    b = txd;
  endtask

  // monitor: one sample per tick interval
  initial begin
    logic b;
    item_t it;
    logic [11:0] eb, gb;
    int n;
    forever begin
      get_bit(b);
      if (b === 1'b0) begin
        if (sb.size() == 0) begin
          check(1'b0, "R11", 1, 0, "frame with nothing expected");
        end else begin
          it = sb.pop_front();
          exp_frame(it, eb, n);
          gb = '1;
          gb[0] = 1'b0;
          for (int i = 1; i < n; i++) begin get_bit(b); gb[i] = b; end
          check(gb === eb, "R2 R3 R4 R6", 32'(gb), 32'(eb), "frame bits");
        end
      end
    end
  end

  task automatic push_byte(input logic [7:0] d, input bit expect_out);
    item_t it;
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    if (expect_out) begin
      it.d = d; it.len = len_code; it.pen = par_en; it.podd = par_odd; it.stop = stop_code;
      sb.push_back(it);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_drain();
    @(negedge clk);
    while (!(fifo_empty && !busy)) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic pe, input logic po, input logic [1:0] s);
    len_code = l; par_en = pe; par_odd = po; stop_code = s;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(txd === 1'b1 && fifo_empty === 1'b1, "R1", {txd, fifo_empty}, 2'b11, "reset line/empty");
    check({fifo_full, busy, wr_err} === 3'b000, "R1", {fifo_full, busy, wr_err}, 0, "reset flags");
    rst_n = 1'b1;
    @(negedge clk);
    check(txd === 1'b1 && busy === 1'b0, "R1", {txd, busy}, 2'b10, "idle after reset");

    // 8 data, no parity, one stop
    set_cfg(2'b00, 1'b0, 1'b0, 2'b00);
    tx_en = 1'b1;
    push_byte(8'h55, 1); push_byte(8'hA3, 1); push_byte(8'hFF, 1); push_byte(8'h00, 1);
    wait_drain();
    check(sb.size() == 0, "R2", sb.size(), 0, "8N1 frames outstanding");

    // 7 data, odd parity, two stops
    set_cfg(2'b01, 1'b1, 1'b1, 2'b01);
    push_byte(8'h80, 1); push_byte(8'h7F, 1); push_byte(8'h13, 1);
    wait_drain();
    check(sb.size() == 0, "R3", sb.size(), 0, "7O2 frames outstanding");

    // 5 data, even parity, one stop; 6 data, no parity, reserved stop code
    set_cfg(2'b11, 1'b1, 1'b0, 2'b00);
    push_byte(8'h1F, 1); push_byte(8'hEA, 1);
    wait_drain();
    set_cfg(2'b10, 1'b0, 1'b0, 2'b11);
    push_byte(8'h2D, 1);
    wait_drain();
    check(sb.size() == 0, "R4", sb.size(), 0, "5E1/6N1 frames outstanding");

    // busy outlives FIFO empty
    set_cfg(2'b00, 1'b0, 1'b0, 2'b00);
    push_byte(8'h3C, 1);
    while (!fifo_empty) @(negedge clk);
    check(busy === 1'b1, "R5", busy, 1, "busy while last frame on line");
    wait_drain();
    check(txd === 1'b1 && sb.size() == 0, "R5", txd, 1, "line idle after completion");

    // disable mid-frame
    tx_en = 1'b0;
    push_byte(8'hC6, 1); push_byte(8'h11, 0); push_byte(8'h22, 0);
    tx_en = 1'b1;
    while (!busy) @(negedge clk);
    tx_en = 1'b0;
    while (busy) @(negedge clk);
    repeat (60) @(negedge clk);
    check(busy === 1'b0 && fifo_empty === 1'b0, "R11", {busy, fifo_empty}, 2'b00, "no new frame while disabled");
    check(sb.size() == 0, "R11", sb.size(), 0, "current frame completed");

    // flush
    @(negedge clk); tx_rst = 1'b1;
    @(negedge clk); tx_rst = 1'b0;
    check(fifo_empty === 1'b1, "R10", fifo_empty, 1, "empty after flush");
    tx_en = 1'b1;
    repeat (60) @(negedge clk);
    check(busy === 1'b0, "R10", busy, 0, "flushed bytes not sent");
    tx_en = 1'b0;

    // fill, threshold, overflow, sticky error
    set_cfg(2'b10, 1'b1, 1'b0, 2'b01);
    irq_en = 1'b1;
    irq_thresh = 8'd32;
    @(negedge clk);
    check(irq === 1'b1, "R9", irq, 1, "irq at zero count");
    for (int k = 1; k <= DEPTH; k++) begin
      push_byte(8'(k * 7 + 3), 1);
      if (k == 32) check(irq === 1'b1, "R9", irq, 1, "irq at count == threshold");
      if (k == 33) check(irq === 1'b0, "R9", irq, 0, "irq above threshold");
    end
    check(fifo_full === 1'b1, "R7", fifo_full, 1, "full at DEPTH");
    check(wr_err === 1'b0, "R8", wr_err, 0, "no error before overflow");
    push_byte(8'hEE, 0);
    check(wr_err === 1'b1 && fifo_full === 1'b1, "R7", {wr_err, fifo_full}, 2'b11, "overflow sets error");
    clr_err = 1'b1;
    @(negedge clk);
    check(wr_err === 1'b0, "R8", wr_err, 0, "cleared by level");
    push_byte(8'hDD, 0);
    check(wr_err === 1'b0, "R8", wr_err, 0, "held clear during overflow");
    clr_err = 1'b0;
    @(negedge clk);
    check(wr_err === 1'b0, "R8", wr_err, 0, "stays clear after release");
    push_byte(8'hCC, 0);
    check(wr_err === 1'b1, "R8", wr_err, 1, "sets again after release");
    irq_en = 1'b0;
    irq_thresh = 8'hFF;
    @(negedge clk);
    check(irq === 1'b0, "R9", irq, 0, "irq masked");
    clr_err = 1'b1; @(negedge clk); clr_err = 1'b0;

    tx_en = 1'b1;
    wait_drain();
    check(sb.size() == 0, "R7", sb.size(), 0, "all DEPTH bytes sent, dropped ones absent");
    repeat (60) @(negedge clk);
    check(busy === 1'b0 && txd === 1'b1, "R7", {busy, txd}, 2'b01, "no frame after drain");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R6 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule